// File: doc/BRIEF.md
# Framed Serial Word Transmitter

This block turns parallel words into a serial bit stream. A bit-period enable (`bit_tick`) stands in for the external bit clock, and a frame-sync input marks where each frame begins. A frame has one or two phases. Each phase has its own word count and word length. The first data bit can lag the sync edge by zero, one or two bit periods. A sync edge that arrives while a frame is still running either restarts the frame or is ignored, depending on configuration.

Software puts words into a one-word holding register. A ready flag and a one-cycle strobe tell it when the register has been copied into the shifter and can take the next word. If a word is due while the register is empty, the old contents go out again and a sticky underflow flag is set. A loopback selector sends the transmitted stream to the receive-side data path in place of the external receive pin.

Top module: `fst_tx`

## Requirements
- R1: After reset, `sdata` is 0, `ready` is 1, `ready_pulse` is 0 and `underflow` is 0.
- R2: While `tx_hold` is 1, `sdata` is 0 from the next clock on. Any frame in progress is abandoned and sync edges start nothing.
- R3: `sdata` changes only on a clock edge where `bit_tick` is 1. The new bit appears after that edge.
- R4: A sync edge is sampled on a tick T as `fsync` 1 with `fsync` 0 at the previous tick. The first data bit is then driven from tick T+d, where d = `cfg_delay`, and code 3 behaves as 2. Before that, `sdata` is 0.
- R5: Bits go out most significant first. When `cfg_lsb_first` is 1 and the phase's word length is 8, bits go out least significant first. The bit comes from the low bits of the written word.
- R6: Length code 0,1,2,3,4,5 gives 8,12,16,20,24,32 bits, and codes 6 and 7 give 32. Each phase uses its own code (`cfg_len_a`, `cfg_len_b`).
- R7: A phase carries its count field plus one words (1..128). When `cfg_dual` is 1, phase B follows phase A with no gap. All words within a frame are back to back.
- R8: On the tick after the last bit of a frame, `sdata` returns to 0. If a sync edge is sampled on that tick, the next frame starts instead, with no gap.
- R9: A sync edge during a running frame (delay or data) restarts the frame when `cfg_ignore` is 0. When `cfg_ignore` is 1, it has no effect on the output.
- R10: A write clears `ready`. Starting a word copies the holding register and sets `ready`. `ready_pulse` is high for one cycle when `ready` goes from 0 to 1.
- R11: Starting a word while `ready` is 1 resends the holding register contents and sets `underflow`, which stays set until reset.
- R12: `rx_data` equals `sdata` when `cfg_loop` is 1 and `rx_pin` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle enable per bit period |
| fsync | input | 1 | Frame sync, sampled on ticks |
| tx_hold | input | 1 | Holds the transmitter idle while 1 |
| cfg_dual | input | 1 | 1 selects two-phase frames |
| cfg_cnt_a | input | 7 | Phase A word count minus one |
| cfg_cnt_b | input | 7 | Phase B word count minus one |
| cfg_len_a | input | 3 | Phase A word length code |
| cfg_len_b | input | 3 | Phase B word length code |
| cfg_delay | input | 2 | Sync-to-first-bit delay in bit periods |
| cfg_ignore | input | 1 | 1 ignores sync edges inside a frame |
| cfg_lsb_first | input | 1 | LSB-first order for 8-bit words |
| cfg_loop | input | 1 | Routes sdata to rx_data |
| rx_pin | input | 1 | External receive data |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 32 | Word to transmit |
| ready | output | 1 | Holding register empty |
| ready_pulse | output | 1 | One-cycle strobe when ready rises |
| underflow | output | 1 | Sticky: a word was resent |
| sdata | output | 1 | Serial data out |
| rx_data | output | 1 | Selected receive-side data |

## Verification
The range assertions on word and bit position assume the configuration inputs stay still while a frame runs. The tick assertion assumes `bit_tick` is the only source of bit timing. The bench changes configuration only while the transmitter is idle. It keeps ticks at least two clocks apart. It writes a word only in the gap between ticks. With that spacing, every write lands well inside a word of eight or more bits.

// File: rtl/fst_pkg.sv
package fst_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 7;
    localparam int LEN_W  = 3;
    localparam int POS_W  = $clog2(DATA_W) + 1;
    localparam int IDX_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_SHIFT = 2'd2
    } fst_state_e;

    // Word length in bits for a length code.
    function automatic logic [POS_W-1:0] len_bits(input logic [LEN_W-1:0] code);
        case (code)
            3'd0:    return POS_W'(8);
            3'd1:    return POS_W'(12);
            3'd2:    return POS_W'(16);
            3'd3:    return POS_W'(20);
            3'd4:    return POS_W'(24);
            default: return POS_W'(32);
        endcase
    endfunction

    // Bit to send at position idx of a word of length len.
    function automatic logic bit_at(input logic [DATA_W-1:0] w,
                                    input logic [POS_W-1:0]  len,
                                    input logic [POS_W-1:0]  idx,
                                    input logic              lsb);
        logic [POS_W-1:0] k;
        if (lsb && (len == POS_W'(8))) k = idx;
        else                           k = len - POS_W'(1) - idx;
        return w[k[IDX_W-1:0]];
    endfunction
endpackage

// File: rtl/fst_hold.sv
module fst_hold
    import fst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] hold_data,
    output logic              ready,
    output logic              ready_pulse,
    output logic              underflow
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              rdy;
        logic              pls;
        logic              unf;
    } hold_s;

    hold_s q, d;

    always_comb begin
        d     = q;
        d.pls = 1'b0;
        if (take) begin
            d.rdy = 1'b1;
            d.pls = ~q.rdy;
            if (q.rdy) d.unf = 1'b1;
        end
        if (wr_en) begin
            d.data = wr_data;
            d.rdy  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.data <= '0;
            q.rdy  <= 1'b1;
            q.pls  <= 1'b0;
            q.unf  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign hold_data   = q.data;
    assign ready       = q.rdy;
    assign ready_pulse = q.pls;
    assign underflow   = q.unf;

    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !ready); // R10
    AST_TAKE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_en) |=> ready); // R10
    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow); // R11
endmodule

// File: rtl/fst_seq.sv
module fst_seq
    import fst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              fsync,
    input  logic              tx_hold,
    input  logic              cfg_dual,
    input  logic [CNT_W-1:0]  cfg_cnt_a,
    input  logic [CNT_W-1:0]  cfg_cnt_b,
    input  logic [LEN_W-1:0]  cfg_len_a,
    input  logic [LEN_W-1:0]  cfg_len_b,
    input  logic [1:0]        cfg_delay,
    input  logic              cfg_ignore,
    input  logic              cfg_lsb_first,
    input  logic [DATA_W-1:0] hold_data,
    output logic              take,
    output logic              sdata
);
    typedef struct packed {
        fst_state_e        state;
        logic              phase;
        logic [CNT_W-1:0]  wcnt;
        logic [POS_W-1:0]  pos;
        logic [1:0]        dly;
        logic [DATA_W-1:0] word;
        logic              fs_prev;
        logic              sd;
    } seq_s;

    seq_s q, d;

    logic [POS_W-1:0] cur_len;
    logic [CNT_W-1:0] cur_cnt;
    logic             fs_edge;
    logic [1:0]       del_eff;
    logic             last_word;
    logic             go_frame, go_word, nph;
    logic [CNT_W-1:0] nwc;

    assign cur_len   = len_bits(q.phase ? cfg_len_b : cfg_len_a);
    assign cur_cnt   = q.phase ? cfg_cnt_b : cfg_cnt_a;
    assign fs_edge   = fsync & ~q.fs_prev;
    assign del_eff   = (cfg_delay == 2'd3) ? 2'd2 : cfg_delay;
    assign last_word = (q.wcnt == cur_cnt) && (q.phase || !cfg_dual);

    always_comb begin
        d        = q;
        take     = 1'b0;
        go_frame = 1'b0;
        go_word  = 1'b0;
        nph      = q.phase;
        nwc      = q.wcnt;
        if (bit_tick) d.fs_prev = fsync;
        if (tx_hold) begin
            d.state = ST_IDLE;
            d.sd    = 1'b0;
            d.pos   = '0;
        end else if (bit_tick) begin
            unique case (q.state)
                ST_IDLE: begin
                    if (fs_edge) go_frame = 1'b1;
                end
                ST_DELAY: begin
                    if (fs_edge && !cfg_ignore) go_frame = 1'b1;
                    else if (q.dly == 2'd0) begin
                        go_word = 1'b1;
                        nph     = 1'b0;
                        nwc     = '0;
                    end else d.dly = q.dly - 2'd1;
                end
                ST_SHIFT: begin
                    if (q.pos == cur_len) begin
                        if (last_word) begin
                            if (fs_edge) go_frame = 1'b1;
                            else begin
                                d.state = ST_IDLE;
                                d.sd    = 1'b0;
                            end
                        end else if (fs_edge && !cfg_ignore) go_frame = 1'b1;
                        else if (q.wcnt == cur_cnt) begin
                            go_word = 1'b1;
                            nph     = 1'b1;
                            nwc     = '0;
                        end else begin
                            go_word = 1'b1;
                            nwc     = q.wcnt + CNT_W'(1);
                        end
                    end else if (fs_edge && !cfg_ignore) go_frame = 1'b1;
                    else begin
                        d.sd  = bit_at(q.word, cur_len, q.pos, cfg_lsb_first);
                        d.pos = q.pos + POS_W'(1);
                    end
                end
                default: d.state = ST_IDLE;
            endcase
            if (go_frame) begin
                if (del_eff == 2'd0) begin
                    go_word = 1'b1;
                    nph     = 1'b0;
                    nwc     = '0;
                end else begin
                    d.state = ST_DELAY;
                    d.dly   = del_eff - 2'd1;
                    d.sd    = 1'b0;
                    d.phase = 1'b0;
                end
            end
            if (go_word) begin
                d.state = ST_SHIFT;
                d.phase = nph;
                d.wcnt  = nwc;
                d.word  = hold_data;
                d.pos   = POS_W'(1);
                d.sd    = bit_at(hold_data, len_bits(nph ? cfg_len_b : cfg_len_a),
                                 '0, cfg_lsb_first);
                take    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state   <= ST_IDLE;
            q.phase   <= 1'b0;
            q.wcnt    <= '0;
            q.pos     <= '0;
            q.dly     <= '0;
            q.word    <= '0;
            q.fs_prev <= 1'b0;
            q.sd      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sdata = q.sd;

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_hold |=> (sdata == 1'b0)); // R2
    AST_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && !tx_hold) |=> $stable(sdata)); // R3
    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SHIFT) |-> (q.pos <= cur_len)); // R6
    AST_WCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SHIFT) |-> (q.wcnt <= cur_cnt)); // R7
    AST_TAKE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (bit_tick && !tx_hold)); // R10
endmodule

// File: rtl/fst_tx.sv
module fst_tx
    import fst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              fsync,
    input  logic              tx_hold,
    input  logic              cfg_dual,
    input  logic [CNT_W-1:0]  cfg_cnt_a,
    input  logic [CNT_W-1:0]  cfg_cnt_b,
    input  logic [LEN_W-1:0]  cfg_len_a,
    input  logic [LEN_W-1:0]  cfg_len_b,
    input  logic [1:0]        cfg_delay,
    input  logic              cfg_ignore,
    input  logic              cfg_lsb_first,
    input  logic              cfg_loop,
    input  logic              rx_pin,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ready,
    output logic              ready_pulse,
    output logic              underflow,
    output logic              sdata,
    output logic              rx_data
);
    logic              take;
    logic [DATA_W-1:0] hold_data;

    fst_hold u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .take        (take),
        .hold_data   (hold_data),
        .ready       (ready),
        .ready_pulse (ready_pulse),
        .underflow   (underflow)
    );

    fst_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_tick      (bit_tick),
        .fsync         (fsync),
        .tx_hold       (tx_hold),
        .cfg_dual      (cfg_dual),
        .cfg_cnt_a     (cfg_cnt_a),
        .cfg_cnt_b     (cfg_cnt_b),
        .cfg_len_a     (cfg_len_a),
        .cfg_len_b     (cfg_len_b),
        .cfg_delay     (cfg_delay),
        .cfg_ignore    (cfg_ignore),
        .cfg_lsb_first (cfg_lsb_first),
        .hold_data     (hold_data),
        .take          (take),
        .sdata         (sdata)
    );

    assign rx_data = cfg_loop ? sdata : rx_pin;

    AST_RX_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_loop && tx_hold) |=> (rx_data == 1'b0 || !cfg_loop)); // R12
endmodule

// File: tb/fst_tx_tb.sv
module fst_tx_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 0, fsync = 0, tx_hold = 0, cfg_dual = 0;
    logic [6:0] cfg_cnt_a = 0, cfg_cnt_b = 0;
    logic [2:0] cfg_len_a = 0, cfg_len_b = 0;
    logic [1:0] cfg_delay = 0;
    logic cfg_ignore = 0, cfg_lsb_first = 0, cfg_loop = 0, rx_pin = 0, wr_en = 0;
    logic [31:0] wr_data = 0;
    logic ready, ready_pulse, underflow, sdata, rx_data;

    int compared = 0, mismatched = 0, pulse_cnt = 0, wseq = 0;
    bit done = 0;
    logic expq[$];

    always #2 clk = ~clk;

    fst_tx u_dut (.*);

    always @(negedge clk) if (ready_pulse) pulse_cnt++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int k);
        return (32'h9E37_79B9 * (k + 1)) ^ 32'h5A3C_C3A5;
    endfunction

    function automatic int blen(input logic [2:0] c);
        case (c)
            0: return 8; 1: return 12; 2: return 16; 3: return 20; 4: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic logic gbit(input logic [31:0] w, input int l, input int i, input bit lsb);
        return (lsb && l == 8) ? w[i] : w[l - 1 - i];
    endfunction

    task automatic write_word(input logic [31:0] v);
        @(negedge clk); wr_en = 1; wr_data = v;
        @(negedge clk); wr_en = 0;
    endtask

    // One bit period; returns the bit driven after it (R3, R12 checked here)
    task automatic tick(input logic fs, output logic b);
        @(negedge clk); fsync = fs; bit_tick = 1; rx_pin = ~rx_pin;
        @(negedge clk); bit_tick = 0; b = sdata;
        check(rx_data == (cfg_loop ? sdata : rx_pin), "R12", rx_data, cfg_loop ? sdata : rx_pin);
        @(negedge clk);
        check(sdata == b, "R3", sdata, b);
    endtask

    task automatic push_word(input logic [31:0] w, input int l, input bit lsb);
        for (int i = 0; i < l; i++) expq.push_back(gbit(w, l, i, lsb));
    endtask

    task automatic frame_run(input bit dual, input int c1, input int c2, input int l1,
                             input int l2, input int dl, input bit lsb, input string tag);
        int nw, fed, deff, nb, p0, k;
        logic b;
        cfg_dual = dual; cfg_cnt_a = 7'(c1); cfg_cnt_b = 7'(c2);
        cfg_len_a = 3'(l1); cfg_len_b = 3'(l2); cfg_delay = 2'(dl); cfg_lsb_first = lsb;
        deff = (dl == 3) ? 2 : dl;
        nw = c1 + 1 + (dual ? c2 + 1 : 0);
        expq.delete();
        k = 0;
        for (int w = 0; w <= c1; w++) begin push_word(pat(wseq + k), blen(3'(l1)), lsb); k++; end
        if (dual) for (int w = 0; w <= c2; w++) begin push_word(pat(wseq + k), blen(3'(l2)), lsb); k++; end
        nb = expq.size();
        p0 = pulse_cnt;
        write_word(pat(wseq)); fed = 1;
        for (int t = 0; t <= deff + nb; t++) begin
            tick(t == 0, b);
            if (t < deff) check(b == 1'b0, "R4", b, 0);
            else if (t - deff < nb) check(b == expq[t - deff], tag, b, expq[t - deff]);
            else check(b == 1'b0, "R8", b, 0);
            if (ready && fed < nw) begin write_word(pat(wseq + fed)); fed++; end
        end
        repeat (3) @(negedge clk);
        check(pulse_cnt - p0 == nw, "R10", pulse_cnt - p0, nw);
        check(underflow == 1'b0, "R11", underflow, 0);
        wseq += nw;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++; compared++;
            $display("FAIL watchdog: actual hang expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic b;
        logic [31:0] wa, wb, wc;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(sdata == 0, "R1", sdata, 0);
        check(ready == 1, "R1", ready, 1);
        check(ready_pulse == 0, "R1", ready_pulse, 0);
        check(underflow == 0, "R1", underflow, 0);

        // Length and delay sweep, single phase, two words
        for (int l = 0; l < 8; l++)
            for (int dl = 0; dl < 4; dl++)
                frame_run(0, 1, 0, l, 0, dl, 0, "R6");
        // Bit order
        frame_run(0, 0, 0, 0, 0, 0, 1, "R5");
        frame_run(0, 2, 0, 0, 0, 1, 1, "R5");
        frame_run(0, 0, 0, 2, 0, 0, 1, "R5");
        // Dual-phase frames, loopback on
        cfg_loop = 1;
        frame_run(1, 0, 0, 0, 5, 0, 0, "R7");
        frame_run(1, 2, 1, 1, 0, 1, 0, "R7");
        frame_run(1, 1, 3, 4, 2, 2, 0, "R7");
        frame_run(1, 3, 0, 5, 3, 0, 1, "R7");
        cfg_loop = 0;

        // Back-to-back frames
        cfg_dual = 0; cfg_cnt_a = 0; cfg_len_a = 0; cfg_delay = 0; cfg_lsb_first = 0;
        wa = pat(100); wb = pat(101);
        write_word(wa);
        tick(1, b); check(b == wa[7], "R8", b, wa[7]);
        write_word(wb);
        for (int i = 1; i < 8; i++) begin tick(0, b); check(b == wa[7-i], "R8", b, wa[7-i]); end
        tick(1, b); check(b == wb[7], "R8", b, wb[7]);
        for (int i = 1; i < 8; i++) begin tick(0, b); check(b == wb[7-i], "R8", b, wb[7-i]); end
        tick(0, b); check(b == 0, "R8", b, 0);

        // Mid-frame sync, restart
        cfg_cnt_a = 1; cfg_ignore = 0;
        wa = pat(110); wb = pat(111); wc = pat(112);
        write_word(wa);
        tick(1, b); check(b == wa[7], "R9", b, wa[7]);
        write_word(wb);
        for (int i = 1; i < 4; i++) tick(0, b);
        check(b == wa[4], "R9", b, wa[4]);
        tick(1, b); check(b == wb[7], "R9", b, wb[7]);
        write_word(wc);
        for (int i = 1; i < 8; i++) begin tick(0, b); check(b == wb[7-i], "R9", b, wb[7-i]); end
        for (int i = 0; i < 8; i++) begin tick(0, b); check(b == wc[7-i], "R9", b, wc[7-i]); end
        tick(0, b); check(b == 0, "R9", b, 0);

        // Mid-frame sync, ignored
        cfg_ignore = 1;
        wa = pat(120); wb = pat(121);
        write_word(wa);
        tick(1, b);
        write_word(wb);
        for (int i = 1; i < 4; i++) tick(0, b);
        tick(1, b); check(b == wa[3], "R9", b, wa[3]);
        for (int i = 5; i < 8; i++) begin tick(0, b); check(b == wa[7-i], "R9", b, wa[7-i]); end
        for (int i = 0; i < 8; i++) begin tick(0, b); check(b == wb[7-i], "R9", b, wb[7-i]); end
        tick(0, b); check(b == 0, "R9", b, 0);
        cfg_ignore = 0;

        // Transmitter hold mid-frame
        cfg_cnt_a = 0;
        wa = 32'hFF;
        write_word(wa);
        tick(1, b); check(b == 1, "R2", b, 1);
        @(negedge clk); tx_hold = 1;
        @(negedge clk); check(sdata == 0, "R2", sdata, 0);
        tick(0, b); tick(1, b); check(b == 0, "R2", b, 0);
        tick(0, b); check(b == 0, "R2", b, 0);
        @(negedge clk); tx_hold = 0;
        tick(0, b); check(b == 0, "R2", b, 0);
        frame_run(0, 0, 0, 1, 0, 0, 0, "R2");

        // Underflow: second word never written
        cfg_cnt_a = 1; cfg_len_a = 0; cfg_delay = 0;
        wa = pat(130);
        write_word(wa);
        tick(1, b); check(b == wa[7], "R11", b, wa[7]);
        for (int i = 1; i < 8; i++) tick(0, b);
        for (int i = 0; i < 8; i++) begin tick(0, b); check(b == wa[7-i], "R11", b, wa[7-i]); end
        check(underflow == 1, "R11", underflow, 1);
        tick(0, b); check(b == 0, "R11", b, 0);
        cfg_cnt_a = 0;
        write_word(pat(131));
        for (int i = 0; i < 9; i++) tick(i == 0, b);
        check(underflow == 1, "R11", underflow, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule